// File: doc/BRIEF.md
# Vectored Interrupt Controller with Rotating Priority

This block gathers up to 64 hardware interrupt lines and routes each one to one of eight output lines: a normal interrupt request line, a fast interrupt request line, or one of six auxiliary lines. Each source has a byte of configuration that holds three fields. The first enables the source. The second picks the trigger: high level, rising edge or falling edge. The third picks the destination line. Edge events are held in latches until software clears them by writing ones to the status words. For a level source, the status bit follows the synchronized input.

Software uses a 32-bit register port. It reads an index register to learn which pending source wins for the normal path and for the fast path. Each path can use fixed priority, where the lowest index wins, or rotating priority. In rotating mode, a read that returns a real source demotes that source to lowest priority for the next arbitration. When no source is pending, the index reads 63. Software then tells "idle" apart from a real source 63 by checking bit 31 of the upper status word.

Top module: `vic_top`

## Requirements
- R1: After reset, the following hold:
  - Every control byte reads 0, so all sources are disabled, set to level trigger and routed to the normal line.
  - Both priority registers read 0.
  - All eight output lines are low.
  - Both index registers read 63.
- R2: The control byte of source n sits at byte lane n%4 of the word at 0x40+4*(n/4). Its fields are:
  - bit 3 enables the source;
  - bits 6:5 select the trigger;
  - bits 2:0 select the destination.
  A disabled source never reaches arbitration or any output line.
- R3: With trigger 00 (level, active high), the status bit shows the input after the two-flop synchronizer. Writes to that status bit have no effect.
- R4: Trigger bit 5 latches a rising edge and trigger bit 6 latches a falling edge. Status bit n%32 of the word at 0x80 (sources 0-31) or 0x84 (sources 32-63) holds the latch.
- R5: Writing 1 to an edge latch's status bit clears it. Writing 0 leaves it unchanged. Only bytes with their byte enable set are affected.
- R6: Each destination has its own output line:
  - destination 0 drives the normal line;
  - destination 1 drives the fast line;
  - destinations 2 to 7 drive aux lines 0 to 5.
  Each line is the registered OR of the pending, enabled sources routed to it.
- R7: The word at 0x00 (normal path) and the word at 0x04 (fast path) return the winning source index in bits 5:0. In fixed mode the lowest pending index wins. When nothing is pending, the index is 63.
- R8: Bit 6 of the word at 0x20 (normal path) and of the word at 0x24 (fast path) selects rotating priority. In rotating mode, each index read that returns a real source makes that source lowest priority for the next arbitration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address; bits 1:0 ignored |
| bus_be | input | 4 | Byte enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while the strobe is high |
| src_i | input | NUM_SRC | Raw interrupt inputs |
| irq_o | output | 1 | Normal interrupt request line |
| fiq_o | output | 1 | Fast interrupt request line |
| aux_o | output | 6 | Auxiliary destination lines |

## Verification
A corrupted edge latch shows up in the status word three cycles after the input edge, and on the routed output line one cycle later. A lost clear keeps the line high past the next clock. An error in the rotation pointer appears only on the second and later index reads of a burst, so the bench reads the index register repeatedly and compares each result with the order it expects. Idle must be distinguished from source 63, so the bench checks both the index register and status bit 31 in both states.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int VIC_MAX_SRC = 64;
  localparam int VIC_IDX_W   = 6;
  localparam int VIC_NUM_DST = 8;

  typedef enum logic [1:0] {
    TRIG_LEVEL = 2'b00,
    TRIG_RISE  = 2'b01,
    TRIG_FALL  = 2'b10,
    TRIG_BOTH  = 2'b11
  } trig_e;

  // per-source configuration byte, bit order fixed by software
  typedef struct packed {
    logic                rsv7;
    trig_e               trig;
    logic                rsv4;
    logic                en;
    logic [2:0]          dest;
  } src_ctrl_t;

  typedef struct packed {
    logic                 hit;
    logic [VIC_IDX_W-1:0] idx;
  } arb_res_t;

  // edge event for the selected trigger polarity
  function automatic logic edge_hit(input trig_e t, input logic cur, input logic prv);
    logic rise_sel, fall_sel;
    rise_sel = (t == TRIG_RISE) || (t == TRIG_BOTH);
    fall_sel = (t == TRIG_FALL) || (t == TRIG_BOTH);
    return (rise_sel & cur & ~prv) | (fall_sel & ~cur & prv);
  endfunction

  // first set bit of req at or after start, wrapping at nsrc
  function automatic arb_res_t arb_pick(input logic [VIC_MAX_SRC-1:0] req,
                                        input logic [VIC_IDX_W-1:0] start,
                                        input int nsrc);
    arb_res_t r;
    int pos;
    r.hit = 1'b0;
    r.idx = VIC_IDX_W'(nsrc - 1);
    for (int k = VIC_MAX_SRC - 1; k >= 0; k--) begin
      if (k < nsrc) begin
        pos = int'(start) + k;
        if (pos >= nsrc) pos = pos - nsrc;
        if (req[pos[VIC_IDX_W-1:0]]) begin
          r.hit = 1'b1;
          r.idx = pos[VIC_IDX_W-1:0];
        end
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/vic_src_cell.sv
module vic_src_cell
  import vic_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  src_in,
  input  trig_e trig,
  input  logic  clr,
  output logic  stat_o,
  output logic  lat_o
);
  logic s1_q, s2_q, s3_q, lat_q;
  logic evt;

  assign evt = edge_hit(trig, s2_q, s3_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q  <= 1'b0;
      s2_q  <= 1'b0;
      s3_q  <= 1'b0;
      lat_q <= 1'b0;
    end else begin
      s1_q <= src_in;
      s2_q <= s1_q;
      s3_q <= s2_q;
      if (trig == TRIG_LEVEL) lat_q <= 1'b0;
      else if (evt)           lat_q <= 1'b1;   // a new event beats a clear
      else if (clr)           lat_q <= 1'b0;
    end
  end

  assign stat_o = (trig == TRIG_LEVEL) ? s2_q : lat_q;
  assign lat_o  = lat_q;
endmodule

// File: rtl/vic_dest_route.sv
module vic_dest_route
  import vic_pkg::*;
#(
  parameter int NUM_SRC = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_SRC-1:0]       pend,
  input  logic [3*NUM_SRC-1:0]     dest_flat,
  output logic [NUM_SRC-1:0]       irq_req,
  output logic [NUM_SRC-1:0]       fiq_req,
  output logic [VIC_NUM_DST-1:0]   line_q
);
  logic [VIC_NUM_DST*NUM_SRC-1:0] sel_flat;
  logic [VIC_NUM_DST-1:0]         any_d;

  for (genvar d = 0; d < VIC_NUM_DST; d++) begin : g_dst
    for (genvar n = 0; n < NUM_SRC; n++) begin : g_bit
      assign sel_flat[d*NUM_SRC+n] = pend[n] && (dest_flat[3*n +: 3] == 3'(d));
    end
    assign any_d[d] = |sel_flat[d*NUM_SRC +: NUM_SRC];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= '0;
    else        line_q <= any_d;
  end

  assign irq_req = sel_flat[0 +: NUM_SRC];
  assign fiq_req = sel_flat[NUM_SRC +: NUM_SRC];
endmodule

// File: rtl/vic_prio_arb.sv
module vic_prio_arb
  import vic_pkg::*;
#(
  parameter int NUM_SRC = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SRC-1:0]   req,
  input  logic                 rotate,
  input  logic                 ack,
  output logic [VIC_IDX_W-1:0] idx_o,
  output logic                 hit_o
);
  localparam logic [VIC_IDX_W-1:0] LAST = VIC_IDX_W'(NUM_SRC - 1);

  logic [VIC_IDX_W-1:0] last_q, start;
  logic [VIC_MAX_SRC-1:0] req_ext;
  arb_res_t res;

  assign req_ext = VIC_MAX_SRC'(req);
  assign start   = (rotate && last_q != LAST) ? last_q + 1'b1 : '0;
  assign res     = arb_pick(req_ext, start, NUM_SRC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       last_q <= LAST;
    else if (ack && res.hit && rotate) last_q <= res.idx;
  end

  assign idx_o = res.idx;
  assign hit_o = res.hit;
endmodule

// File: rtl/vic_top.sv
module vic_top
  import vic_pkg::*;
#(
  parameter int NUM_SRC = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_we,
  input  logic [7:0]         bus_addr,
  input  logic [3:0]         bus_be,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic [NUM_SRC-1:0] src_i,
  output logic               irq_o,
  output logic               fiq_o,
  output logic [5:0]         aux_o
);
  localparam int CTRL_WORDS = NUM_SRC / 4;
  localparam int STAT_WORDS = NUM_SRC / 32;
  localparam int ROT_BIT    = 6;
  localparam logic [5:0] W_IRQ_IDX = 6'h00;
  localparam logic [5:0] W_FIQ_IDX = 6'h01;
  localparam logic [5:0] W_IRQ_PRI = 6'h08;
  localparam logic [5:0] W_FIQ_PRI = 6'h09;
  localparam logic [5:0] W_CTRL0   = 6'h10;
  localparam logic [5:0] W_STAT0   = 6'h20;

  logic [5:0]               word_a;
  logic                     wr_en, rd_en;
  logic [8*NUM_SRC-1:0]     ctrl_flat;
  logic [3*NUM_SRC-1:0]     dest_flat;
  logic [NUM_SRC-1:0]       en_vec, edge_mode, stat_vec, lat_vec, clr_vec, pend_vec;
  logic [NUM_SRC-1:0]       irq_req, fiq_req;
  logic [VIC_IDX_W-1:0]     irq_idx, fiq_idx;
  logic                     irq_hit, fiq_hit;
  logic                     irq_rot_q, fiq_rot_q;
  logic                     irq_ack, fiq_ack;
  logic [VIC_NUM_DST-1:0]   line_q;

  assign word_a = bus_addr[7:2];
  assign wr_en  = bus_sel &  bus_we;
  assign rd_en  = bus_sel & ~bus_we;

  for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
    localparam int CW   = n / 4;
    localparam int LANE = n % 4;
    localparam int SW   = n / 32;
    localparam int SB   = n % 32;
    src_ctrl_t ctrl_r;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctrl_r <= '0;
      else if (wr_en && word_a == 6'(W_CTRL0 + CW) && bus_be[LANE])
        ctrl_r <= src_ctrl_t'(bus_wdata[8*LANE +: 8]);
    end

    assign ctrl_flat[8*n +: 8] = ctrl_r;
    assign dest_flat[3*n +: 3] = ctrl_r.dest;
    assign en_vec[n]           = ctrl_r.en;
    assign edge_mode[n]        = (ctrl_r.trig != TRIG_LEVEL);
    assign clr_vec[n]          = wr_en && word_a == 6'(W_STAT0 + SW) &&
                                 bus_be[SB/8] && bus_wdata[SB];

    vic_src_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .src_in (src_i[n]),
      .trig   (ctrl_r.trig),
      .clr    (clr_vec[n]),
      .stat_o (stat_vec[n]),
      .lat_o  (lat_vec[n])
    );
  end

  assign pend_vec = stat_vec & en_vec;

  vic_dest_route #(.NUM_SRC(NUM_SRC)) u_route (
    .clk       (clk),
    .rst_n     (rst_n),
    .pend      (pend_vec),
    .dest_flat (dest_flat),
    .irq_req   (irq_req),
    .fiq_req   (fiq_req),
    .line_q    (line_q)
  );

  assign irq_ack = rd_en && word_a == W_IRQ_IDX;
  assign fiq_ack = rd_en && word_a == W_FIQ_IDX;

  vic_prio_arb #(.NUM_SRC(NUM_SRC)) u_irq_arb (
    .clk    (clk),
    .rst_n  (rst_n),
    .req    (irq_req),
    .rotate (irq_rot_q),
    .ack    (irq_ack),
    .idx_o  (irq_idx),
    .hit_o  (irq_hit)
  );

  vic_prio_arb #(.NUM_SRC(NUM_SRC)) u_fiq_arb (
    .clk    (clk),
    .rst_n  (rst_n),
    .req    (fiq_req),
    .rotate (fiq_rot_q),
    .ack    (fiq_ack),
    .idx_o  (fiq_idx),
    .hit_o  (fiq_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_rot_q <= 1'b0;
      fiq_rot_q <= 1'b0;
    end else if (wr_en && bus_be[0]) begin
      if (word_a == W_IRQ_PRI) irq_rot_q <= bus_wdata[ROT_BIT];
      if (word_a == W_FIQ_PRI) fiq_rot_q <= bus_wdata[ROT_BIT];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (word_a == W_IRQ_IDX) bus_rdata = 32'(irq_idx);
    if (word_a == W_FIQ_IDX) bus_rdata = 32'(fiq_idx);
    if (word_a == W_IRQ_PRI) bus_rdata[ROT_BIT] = irq_rot_q;
    if (word_a == W_FIQ_PRI) bus_rdata[ROT_BIT] = fiq_rot_q;
    for (int j = 0; j < CTRL_WORDS; j++)
      if (word_a == 6'(W_CTRL0 + j)) bus_rdata = ctrl_flat[32*j +: 32];
    for (int w = 0; w < STAT_WORDS; w++)
      if (word_a == 6'(W_STAT0 + w)) bus_rdata = stat_vec[32*w +: 32];
  end

  assign irq_o = line_q[0];
  assign fiq_o = line_q[1];
  assign aux_o = line_q[7:2];
endmodule

// File: rtl/vic_checker.sv
module vic_checker #(
  parameter int NUM_SRC = 64
) (
  input logic               clk,
  input logic               rst_n,
  input logic               irq_o,
  input logic               fiq_o,
  input logic [NUM_SRC-1:0] irq_req,
  input logic [NUM_SRC-1:0] fiq_req,
  input logic [5:0]         irq_idx,
  input logic [5:0]         fiq_idx,
  input logic               irq_rot,
  input logic [NUM_SRC-1:0] lat_vec,
  input logic [NUM_SRC-1:0] edge_mode,
  input logic [NUM_SRC-1:0] clr_vec
);
  logic [NUM_SRC-1:0] below_irq;
  always_comb
    for (int k = 0; k < NUM_SRC; k++) below_irq[k] = (k < int'(irq_idx));

  // R6: a routed pending source raises its line one cycle later
  a_r6_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_req) |=> irq_o);
  a_r6_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(|irq_req) |=> !irq_o);
  a_r6_fiq_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (|fiq_req) |=> fiq_o);
  // R7: idle index value and winner validity
  a_r7_irq_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !(|irq_req) |-> (irq_idx == 6'(NUM_SRC - 1)));
  a_r7_irq_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_req) |-> irq_req[irq_idx]);
  a_r7_fiq_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (|fiq_req) |-> fiq_req[fiq_idx]);
  // R7: fixed mode never skips a lower pending index
  a_r7_fixed_lowest: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_rot && (|irq_req)) |-> ((irq_req & below_irq) == '0));
  // R5: an edge latch only drops on a clear or a mode change
  a_r5_edge_hold: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(lat_vec) & ~$past(clr_vec) & $past(edge_mode) & ~lat_vec) == '0));
endmodule

bind vic_top vic_checker #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq_o     (irq_o),
  .fiq_o     (fiq_o),
  .irq_req   (irq_req),
  .fiq_req   (fiq_req),
  .irq_idx   (irq_idx),
  .fiq_idx   (fiq_idx),
  .irq_rot   (irq_rot_q),
  .lat_vec   (lat_vec),
  .edge_mode (edge_mode),
  .clr_vec   (clr_vec)
);

// File: tb/vic_top_tb.sv
`timescale 1ns/1ps
module vic_top_tb;
  localparam int NSRC = 64;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            bus_sel = 1'b0;
  logic            bus_we = 1'b0;
  logic [7:0]      bus_addr = '0;
  logic [3:0]      bus_be = '0;
  logic [31:0]     bus_wdata = '0;
  logic [31:0]     bus_rdata;
  logic [NSRC-1:0] src_i = '0;
  logic            irq_o, fiq_o;
  logic [5:0]      aux_o;

  int n_tests = 0;
  int n_fail  = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  vic_top #(.NUM_SRC(NSRC)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .src_i(src_i), .irq_o(irq_o), .fiq_o(fiq_o),
    .aux_o(aux_o)
  );

  // monitor: pops the scoreboard on every read strobe
  always @(negedge clk) begin
    if (bus_sel && !bus_we && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_tests++;
      if (bus_rdata !== e) begin
        n_fail++;
        $display("FAIL %s: read 0x%02h got %08h expected %08h", t, bus_addr, bus_rdata, e);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
    @(posedge clk); #2;
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(posedge clk); #2;
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic sb_read(input logic [7:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(posedge clk); #2;
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(posedge clk); #2;
    bus_sel = 1'b0;
  endtask

  task automatic chk(input logic [31:0] got, input logic [31:0] e, input string t);
    n_tests++;
    if (got !== e) begin
      n_fail++;
      $display("FAIL %s: got %08h expected %08h", t, got, e);
    end
  endtask

  initial begin
    #1_000_000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: run did not finish, got hang expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(2);
    // R1 reset state
    sb_read(8'h00, 32'd63, "R1 irq index idle");
    sb_read(8'h04, 32'd63, "R1 fiq index idle");
    sb_read(8'h84, 32'h0,  "R1 status high");
    sb_read(8'h40, 32'h0,  "R1 control word");
    sb_read(8'h20, 32'h0,  "R1 irq prio");
    chk({25'b0, irq_o, fiq_o, aux_o}, 32'h0, "R1 lines low");

    // level source 5 to normal line: byte 0x08 in lane 1 of word 0x44
    bus_write(8'h44, 32'h0000_0800, 4'b0010);
    src_i[5] = 1'b1;
    tick(5);
    chk({31'b0, irq_o}, 32'h1, "R6 irq line from source 5");
    sb_read(8'h00, 32'd5,  "R7 index source 5");
    sb_read(8'h80, 32'h20, "R3 level status");
    sb_read(8'h44, 32'h0000_0800, "R2 control readback");

    // source 7 high but disabled
    src_i[7] = 1'b1;
    tick(5);
    sb_read(8'h80, 32'hA0, "R3 live status of disabled source");
    sb_read(8'h00, 32'd5,  "R2 disabled source ignored");

    // source 3 level, enabled: fixed priority picks lowest
    bus_write(8'h40, 32'h0800_0000, 4'b1000);
    src_i[3] = 1'b1;
    tick(5);
    sb_read(8'h00, 32'd3, "R7 fixed lowest wins");
    sb_read(8'h00, 32'd3, "R7 fixed repeats");
    bus_write(8'h80, 32'hFFFF_FFFF, 4'hF);
    sb_read(8'h80, 32'hA8, "R3 level ignores write");

    // rotating priority on the normal path
    bus_write(8'h20, 32'h40, 4'b0001);
    sb_read(8'h20, 32'h40, "R8 prio readback");
    sb_read(8'h00, 32'd3, "R8 rotate first");
    sb_read(8'h00, 32'd5, "R8 rotate second");
    sb_read(8'h00, 32'd3, "R8 rotate wraps");

    // drop sources
    bus_write(8'h40, 32'h0, 4'b1000);
    bus_write(8'h44, 32'h0, 4'b0010);
    src_i[3] = 1'b0; src_i[5] = 1'b0; src_i[7] = 1'b0;
    tick(5);
    chk({31'b0, irq_o}, 32'h0, "R6 irq line drops");
    sb_read(8'h00, 32'd63, "R7 idle after drop");

    // rising edge source 10 to fast line: byte 0x29 in lane 2 of word 0x48
    bus_write(8'h48, 32'h0029_0000, 4'b0100);
    sb_read(8'h48, 32'h0029_0000, "R2 edge control readback");
    src_i[10] = 1'b1; tick(3); src_i[10] = 1'b0;
    tick(5);
    sb_read(8'h80, 32'h400, "R4 rising latched");
    chk({30'b0, fiq_o, irq_o}, 32'h2, "R6 fast line only");
    sb_read(8'h04, 32'd10, "R7 fiq index");
    sb_read(8'h00, 32'd63, "R6 not routed to irq");
    bus_write(8'h80, 32'h0, 4'hF);
    sb_read(8'h80, 32'h400, "R5 write zero keeps");
    bus_write(8'h80, 32'h400, 4'hF);
    sb_read(8'h80, 32'h0, "R5 write one clears");
    tick(2);
    chk({31'b0, fiq_o}, 32'h0, "R5 fast line clears");
    sb_read(8'h04, 32'd63, "R7 fiq idle");

    // falling edge source 40 to aux 2: byte 0x4C in lane 0 of word 0x68
    src_i[40] = 1'b1;
    tick(5);
    bus_write(8'h68, 32'h0000_004C, 4'b0001);
    tick(3);
    sb_read(8'h84, 32'h0, "R4 no event on mode switch");
    src_i[40] = 1'b0;
    tick(5);
    sb_read(8'h84, 32'h100, "R4 falling latched");
    chk({26'b0, aux_o}, 32'h4, "R6 aux line 2");
    bus_write(8'h84, 32'h100, 4'b0001);
    sb_read(8'h84, 32'h100, "R5 other lane no clear");
    bus_write(8'h84, 32'h100, 4'b0010);
    sb_read(8'h84, 32'h0, "R5 lane clear");
    src_i[40] = 1'b1;
    tick(5);
    sb_read(8'h84, 32'h0, "R4 rising ignored in falling mode");

    // source 63 versus idle
    bus_write(8'h7C, 32'h0800_0000, 4'b1000);
    src_i[63] = 1'b1;
    tick(5);
    sb_read(8'h00, 32'd63, "R7 real source 63");
    sb_read(8'h84, 32'h8000_0000, "R7 status bit 31 set");
    chk({31'b0, irq_o}, 32'h1, "R6 irq from 63");
    src_i[63] = 1'b0;
    tick(5);
    sb_read(8'h00, 32'd63, "R7 idle reads 63");
    sb_read(8'h84, 32'h0, "R7 status bit 31 clear");

    // rotating priority on the fast path: sources 12 and 13, byte 0x09
    bus_write(8'h4C, 32'h0000_0909, 4'b0011);
    bus_write(8'h24, 32'h40, 4'b0001);
    src_i[12] = 1'b1; src_i[13] = 1'b1;
    tick(5);
    sb_read(8'h04, 32'd12, "R8 fiq rotate first");
    sb_read(8'h04, 32'd13, "R8 fiq rotate second");
    sb_read(8'h04, 32'd12, "R8 fiq rotate wraps");

    tick(2);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule